// File: doc/BRIEF.md
# Preemptive Bus Arbiter with Parking

This block is the central arbiter for a shared parallel bus driven by several masters. Each master has an active-low request line and receives an active-low grant line. The arbiter samples the requests on each rising clock edge and drives one registered grant. A master that holds the grant keeps it for as long as no other master asks for the bus. It can therefore run bursts of any length and start new transactions back to back with no idle cycle between them. When the bus has no requests at all, the grant stays parked on the most recent holder.

When another master raises its request, the arbiter acts according to the bus state. If a transfer is in progress, the arbiter withdraws the holder's grant, and the holder gives up the bus on the following cycle. The bus counts as idle only when both the frame line and the initiator-ready line are high. Once the bus is idle, the arbiter passes the grant to the next requester in round-robin order, starting after the last holder. If a competitor appears while the bus is already idle, the grant moves straight to the round-robin winner in one step, with no empty cycle in between.

Top module: `bus_arbiter`

## Requirements
- R1: During and right after synchronous reset, only master 0 is granted: gnt_n has bit 0 low and all other bits high.
- R2: In every cycle, at most one bit of gnt_n is low.
- R3: When a single master other than the holder asserts its request (low) and the bus is idle (frame_n and irdy_n both high), its grant goes low at the next rising edge.
- R4: While no master other than the holder is requesting, the holder's grant stays unchanged across any number of cycles, whatever frame_n and irdy_n do, and whether or not the holder itself is requesting.
- R5: When another master requests while the bus is busy (frame_n or irdy_n low) and a grant is asserted, every grant line is high after the next rising edge.
- R6: While no grant is asserted and the bus stays busy, no grant is asserted.
- R7: When another master requests while the bus is idle and a grant is asserted, the grant moves to the winner at the next edge, with no cycle in which all grants are high.
- R8: The winner is the first requesting master in increasing index order, wrapping from the highest index to 0, starting at the index just after the last holder.
- R9: With no requests, the grant stays on the last holder. If the grant was withdrawn and the bus becomes idle with no requests, the grant returns to the last holder at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_n | input | NUM_MASTERS | Per-master request, active low |
| frame_n | input | 1 | Bus frame line, active low; low means a transaction is in progress |
| irdy_n | input | 1 | Initiator-ready line, active low |
| gnt_n | output | NUM_MASTERS | Per-master grant, active low, registered |

## Verification
The bench keeps a holder busy for a long burst and toggles the frame line between transfers. A design that treated the owner's own request or a short idle gap as a reason to re-arbitrate would drop the grant, and the bench would see it fall. The bench also raises a competitor mid-burst and holds the bus busy for several more cycles. An arbiter that handed over at once would assert a second grant on a busy bus, and one that never preempted would leave the old grant low. Two further scenarios follow. One runs all four masters requesting on an idle bus, where a wrong starting point in the rotation shows up as an out-of-order grant. The other withdraws the competitor after preemption, where a design that forgot the last holder would leave the bus with no grant once it goes idle.

// File: rtl/busarb_pkg.sv
package busarb_pkg;
  // Action chosen by the arbiter controller in a cycle
  typedef enum logic [1:0] {
    ACT_KEEP = 2'd0,  // holder keeps the grant
    ACT_DROP = 2'd1,  // withdraw grant, bus still busy
    ACT_PASS = 2'd2,  // bus idle: grant the picked master (or re-park)
    ACT_WAIT = 2'd3   // no grant, waiting for the bus to go idle
  } arb_act_e;
endpackage

// File: rtl/bus_idle_det.sv
module bus_idle_det (
  input  logic frame_n,
  input  logic irdy_n,
  output logic idle
);
  // Idle only when neither frame nor initiator-ready is asserted
  assign idle = frame_n & irdy_n;
endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last,
  output logic [IW-1:0] win,
  output logic          win_valid
);
  int idx;
  always_comb begin
    win       = last;
    win_valid = 1'b0;
    idx       = 0;
    for (int k = 1; k <= N; k++) begin
      idx = (int'(last) + k) % N;
      if (!win_valid && req[idx]) begin
        win_valid = 1'b1;
        win       = IW'(idx);
      end
    end
  end
endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter #(
  parameter int NUM_MASTERS = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_MASTERS-1:0] req_n,
  input  logic                   frame_n,
  input  logic                   irdy_n,
  output logic [NUM_MASTERS-1:0] gnt_n
);
  import busarb_pkg::*;

  localparam int N  = NUM_MASTERS;
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]  req_a;
  logic [N-1:0]  owner_mask;
  logic [N-1:0]  rivals;
  logic [N-1:0]  gnt_next;
  logic [IW-1:0] owner_q, owner_d, win;
  logic          held_q, held_d, win_valid, idle;
  arb_act_e      act;

  assign req_a = ~req_n;

  bus_idle_det u_idle (
    .frame_n (frame_n),
    .irdy_n  (irdy_n),
    .idle    (idle)
  );

  rr_pick #(.N(N), .IW(IW)) u_pick (
    .req       (req_a),
    .last      (owner_q),
    .win       (win),
    .win_valid (win_valid)
  );

  always_comb begin
    owner_mask = '0;
    owner_mask[owner_q] = 1'b1;
    rivals = req_a & ~owner_mask;
  end

  // Policy: keep while uncontested, drop on a busy bus, pass on an idle bus
  always_comb begin
    if (held_q) begin
      if (rivals == '0)  act = ACT_KEEP;
      else if (idle)     act = ACT_PASS;
      else               act = ACT_DROP;
    end else begin
      act = idle ? ACT_PASS : ACT_WAIT;
    end
  end

  always_comb begin
    owner_d = owner_q;
    held_d  = held_q;
    unique case (act)
      ACT_KEEP, ACT_WAIT: ;
      ACT_DROP: held_d = 1'b0;
      ACT_PASS: begin
        held_d  = 1'b1;
        owner_d = win_valid ? win : owner_q;
      end
      default: ;
    endcase
    gnt_next = '1;
    if (held_d) gnt_next[owner_d] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      owner_q <= '0;
      held_q  <= 1'b1;
      gnt_n   <= {{(N-1){1'b1}}, 1'b0};
    end else begin
      owner_q <= owner_d;
      held_q  <= held_d;
      gnt_n   <= gnt_next;
    end
  end
endmodule

// File: rtl/bus_arbiter_chk.sv
module bus_arbiter_chk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] req_n,
  input logic         frame_n,
  input logic         irdy_n,
  input logic [N-1:0] gnt_n
);
  logic         bus_idle;
  logic [N-1:0] rival_req;
  logic         any_gnt;

  assign bus_idle  = frame_n & irdy_n;
  assign rival_req = ~req_n & gnt_n;
  assign any_gnt   = (gnt_n != '1);

  assert_single_grant_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~gnt_n));

  assert_hold_uncontested_R4: assert property (@(posedge clk) disable iff (rst)
    (any_gnt && rival_req == '0) |=> $stable(gnt_n));

  assert_preempt_busy_R5: assert property (@(posedge clk) disable iff (rst)
    (any_gnt && rival_req != '0 && !bus_idle) |=> (gnt_n == '1));

  assert_no_grant_busy_R6: assert property (@(posedge clk) disable iff (rst)
    (!any_gnt && !bus_idle) |=> (gnt_n == '1));

  assert_idle_handover_R7: assert property (@(posedge clk) disable iff (rst)
    (any_gnt && rival_req != '0 && bus_idle) |=> (gnt_n != '1 && !$stable(gnt_n)));

  assert_regrant_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (!any_gnt && bus_idle) |=> (gnt_n != '1));
endmodule

bind bus_arbiter bus_arbiter_chk #(.N(NUM_MASTERS)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .req_n   (req_n),
  .frame_n (frame_n),
  .irdy_n  (irdy_n),
  .gnt_n   (gnt_n)
);

// File: tb/bus_arbiter_test.sv
module bus_arbiter_test;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] req_n = '1;
  logic         frame_n = 1'b1;
  logic         irdy_n = 1'b1;
  logic [N-1:0] gnt_n;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  bus_arbiter #(.NUM_MASTERS(N)) uut (
    .clk(clk), .rst(rst), .req_n(req_n),
    .frame_n(frame_n), .irdy_n(irdy_n), .gnt_n(gnt_n)
  );

  task automatic check_gnt(input logic [N-1:0] exp, input string req_tag);
    checks++;
    if (gnt_n !== exp) begin
      failures++;
      $display("FAIL %s: gnt_n=%b expected %b", req_tag, gnt_n, exp);
    end
    checks++;
    if ($countones(~gnt_n) > 1) begin
      failures++;
      $display("FAIL R2: gnt_n=%b expected at most one low bit", gnt_n);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic bus(input logic busy);
    frame_n = ~busy;
    irdy_n  = ~busy;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    step(); step();
    rst = 1'b0;
    check_gnt(4'b1110, "R1");
  endtask

  task automatic t_park();
    req_n = '1; bus(1'b0);
    for (int i = 0; i < 5; i++) begin
      step();
      check_gnt(4'b1110, "R9");
    end
  endtask

  task automatic t_single();
    req_n = 4'b1011; bus(1'b0);
    step();
    check_gnt(4'b1011, "R3");
  endtask

  task automatic t_burst();
    bus(1'b1);
    for (int i = 0; i < 10; i++) begin
      step();
      check_gnt(4'b1011, "R4");
    end
    bus(1'b0); step(); check_gnt(4'b1011, "R4");
    bus(1'b1); step(); check_gnt(4'b1011, "R4");
    req_n = '1; step(); check_gnt(4'b1011, "R4");
    req_n = 4'b1011; step(); check_gnt(4'b1011, "R4");
  endtask

  task automatic t_preempt();
    bus(1'b1);
    req_n = 4'b1010;
    step();
    check_gnt(4'b1111, "R5");
    for (int i = 0; i < 3; i++) begin
      step();
      check_gnt(4'b1111, "R6");
    end
    bus(1'b0);
    step();
    check_gnt(4'b1110, "R8");
    req_n = '1;
    step();
    check_gnt(4'b1110, "R9");
  endtask

  task automatic t_repark();
    bus(1'b1);
    req_n = 4'b1101;
    step();
    check_gnt(4'b1111, "R5");
    req_n = '1;
    step();
    check_gnt(4'b1111, "R6");
    bus(1'b0);
    step();
    check_gnt(4'b1110, "R9");
  endtask

  task automatic t_rotate();
    bus(1'b0);
    req_n = 4'b0000;
    step(); check_gnt(4'b1101, "R7");
    step(); check_gnt(4'b1011, "R8");
    step(); check_gnt(4'b0111, "R8");
    step(); check_gnt(4'b1110, "R8");
    req_n = '1;
    step(); check_gnt(4'b1110, "R9");
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog: run did not complete, expected finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    step();
    t_reset();
    t_park();
    t_single();
    t_burst();
    t_preempt();
    t_repark();
    t_rotate();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule